// File: doc/BRIEF.md
# Software Interrupt Request Generator

This block turns register writes from CPUs into software interrupt pending state. A CPU writes a command word to the generate register. The word names one of 16 software interrupt IDs and a routing mode. The block works out the destination CPUs from the routing mode, the target mask and the ID of the writing CPU. For each destination it records that this source CPU raised this interrupt ID. Pending state is held separately for every (target CPU, interrupt ID, source CPU) triple, so two sources that raise the same ID on one target stay distinguishable.

Two register banks give direct access to the pending state of the CPU that performs the access. One bank sets pending bits and the other clears them. The same words read back that CPU's pending state. For each target CPU the block drives a 16-bit vector that shows which interrupt IDs are pending from any source. Arbitrating between pending interrupts and delivering them to a processor are left to logic downstream. The CPU count is a parameter from 1 to 8.

Top module: `sgi_gen`

## Requirements
- R1: After synchronous reset every pending bit is clear: `sgi_pend` is zero and both banks read zero.
- R2: A write to offset 0xF00 is a generate command. Bits [3:0] give the interrupt ID, bits [23:16] the target mask (bit n selects CPU n) and bits [25:24] the route. With route 0, every CPU in the mask records the ID as pending from the writing CPU.
- R3: Route 1 marks the ID pending, from the writer, on every implemented CPU except the writer. The target mask is ignored.
- R4: Route 2 marks the ID pending, from the writer, only on the writer itself. The target mask is ignored.
- R5: Route 3 is reserved, and a command that uses it changes no pending state.
- R6: Target mask bits at or above NUM_CPU are dropped without effect.
- R7: Pending state is kept per source. A second source raising the same ID on the same target sets a separate bit, and raising an already pending pair again leaves it pending.
- R8: A write to the set bank at 0xF20 + 4*w sets pending state on the writing CPU. In that word, byte b covers ID 4*w+b and bit s of the byte covers source CPU s. Each 1 bit sets that pair, and 0 bits change nothing.
- R9: A write to the clear bank at 0xF10 + 4*w uses the same layout. Each 1 bit clears that pair on the writing CPU, and 0 bits change nothing.
- R10: A read of either bank returns the reading CPU's pending state in the R8 layout. Bits for source IDs at or above NUM_CPU read as 0, and so does the generate offset.
- R11: `sgi_pend[16*t+i]` is 1 exactly when ID i is pending on CPU t from at least one source. It changes on the clock edge that samples the write.
- R12: Writes to any other offset, unaligned bank offsets, and any access with `acc_cpu` >= NUM_CPU change nothing. Such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_cpu | input | 3 | ID of the CPU performing the access |
| acc_addr | input | 12 | Register byte offset |
| acc_we | input | 1 | Write strobe, sampled on the rising edge |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_cpu and acc_addr (combinational) |
| sgi_pend | output | 16*NUM_CPU | Per-target pending-by-ID vector, 16 bits per CPU |

## Verification
On every cycle, the assertions check the route decode: reserved commands leave the pending outputs unchanged, route 1 never hits the writer, route 2 hits only the writer, and route 0 follows the implemented part of the mask. They also check that the set and clear masks a bank receives take effect on the next edge, and that a bank receives no update holds its state. How pending bits from different sources combine is shown only by the bench's scenarios, which compare against a behavioural model of every (target, ID, source) bit on every clock. The scenarios also cover the byte and bit layout seen on readback, the dropping of out-of-range targets and requesters, and the fact that a clear leaves a target pending while another source still holds the same ID.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SGI_NUM      = 16;
    localparam int SGI_ID_W     = 4;
    localparam int CPU_MAX      = 8;
    localparam int CPU_ID_W     = 3;
    localparam int REG_ADDR_W   = 12;
    localparam int REG_DATA_W   = 32;
    localparam int SGI_PER_WORD = REG_DATA_W / CPU_MAX;
    localparam int PEND_WORDS   = SGI_NUM / SGI_PER_WORD;
    localparam int WORD_IDX_W   = $clog2(PEND_WORDS);

    localparam logic [REG_ADDR_W-1:0] GEN_OFS  = 12'hF00;
    localparam logic [REG_ADDR_W-1:0] CLR_BASE = 12'hF10;
    localparam logic [REG_ADDR_W-1:0] SET_BASE = 12'hF20;
    localparam logic [REG_ADDR_W-1:0] BANK_SPAN = REG_ADDR_W'(4 * PEND_WORDS);

    typedef enum logic [1:0] {
        RT_LIST   = 2'd0,
        RT_OTHERS = 2'd1,
        RT_SELF   = 2'd2,
        RT_RSVD   = 2'd3
    } route_e;

    typedef struct packed {
        route_e                route;
        logic [CPU_MAX-1:0]    mask;
        logic [SGI_ID_W-1:0]   id;
    } gen_cmd_t;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_CLR  = 2'd1,
        BK_SET  = 2'd2
    } bank_e;

    typedef struct packed {
        bank_e                 bank;
        logic [WORD_IDX_W-1:0] word;
    } pend_sel_t;

    function automatic gen_cmd_t decode_gen(input logic [REG_DATA_W-1:0] w);
        gen_cmd_t c;
        c.id    = w[SGI_ID_W-1:0];
        c.mask  = w[16 +: CPU_MAX];
        c.route = route_e'(w[25:24]);
        return c;
    endfunction

    function automatic pend_sel_t decode_pend(input logic [REG_ADDR_W-1:0] a);
        pend_sel_t             s;
        logic [REG_ADDR_W-1:0] off;
        s.bank = BK_NONE;
        s.word = '0;
        off    = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= CLR_BASE && a < CLR_BASE + BANK_SPAN) begin
                s.bank = BK_CLR;
                off    = a - CLR_BASE;
            end else if (a >= SET_BASE && a < SET_BASE + BANK_SPAN) begin
                s.bank = BK_SET;
                off    = a - SET_BASE;
            end
        end
        s.word = off[WORD_IDX_W+1:2];
        return s;
    endfunction

endpackage

// File: rtl/sgi_route.sv
module sgi_route
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  gen_cmd_t              cmd,
    input  logic [CPU_ID_W-1:0]   src,
    output logic [NUM_CPU-1:0]    tgt
);
    always_comb begin
        for (int t = 0; t < NUM_CPU; t++) begin
            unique case (cmd.route)
                RT_LIST:   tgt[t] = cmd.mask[t];
                RT_OTHERS: tgt[t] = (src != CPU_ID_W'(t));
                RT_SELF:   tgt[t] = (src == CPU_ID_W'(t));
                default:   tgt[t] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SGI_NUM*NUM_CPU-1:0]    set_vec,
    input  logic [SGI_NUM*NUM_CPU-1:0]    clr_vec,
    output logic [SGI_NUM*NUM_CPU-1:0]    state,
    output logic [SGI_NUM-1:0]            any
);
    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= (state & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < SGI_NUM; i++) begin : g_any
        assign any[i] = |state[i*NUM_CPU +: NUM_CPU];
    end

    // R8
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((state & $past(set_vec)) == $past(set_vec)));

    // R9
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0 && set_vec == '0) |=> ((state & $past(clr_vec)) == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(state));
endmodule

// File: rtl/sgi_pend_regs.sv
module sgi_pend_regs
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [REG_ADDR_W-1:0]         acc_addr,
    input  logic                          wr_ok,
    input  logic [REG_DATA_W-1:0]         acc_wdata,
    input  logic [SGI_NUM*NUM_CPU-1:0]    rd_state,
    output logic [SGI_NUM*NUM_CPU-1:0]    wr_set,
    output logic [SGI_NUM*NUM_CPU-1:0]    wr_clr,
    output logic [REG_DATA_W-1:0]         rdata
);
    pend_sel_t                       sel;
    logic [SGI_NUM*NUM_CPU-1:0]      mask;

    assign sel = decode_pend(acc_addr);

    always_comb begin
        mask  = '0;
        rdata = '0;
        for (int i = 0; i < SGI_NUM; i++) begin
            if (i / SGI_PER_WORD == int'(sel.word)) begin
                for (int s = 0; s < NUM_CPU; s++) begin
                    mask[i*NUM_CPU + s] = acc_wdata[(i % SGI_PER_WORD)*CPU_MAX + s];
                    if (sel.bank != BK_NONE)
                        rdata[(i % SGI_PER_WORD)*CPU_MAX + s] = rd_state[i*NUM_CPU + s];
                end
            end
        end
    end

    assign wr_set = (wr_ok && sel.bank == BK_SET) ? mask : '0;
    assign wr_clr = (wr_ok && sel.bank == BK_CLR) ? mask : '0;
endmodule

// File: rtl/sgi_gen.sv
module sgi_gen
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [2:0]                   acc_cpu,
    input  logic [11:0]                  acc_addr,
    input  logic                         acc_we,
    input  logic [31:0]                  acc_wdata,
    output logic [31:0]                  acc_rdata,
    output logic [SGI_NUM*NUM_CPU-1:0]   sgi_pend
);
    localparam int PW = SGI_NUM * NUM_CPU;

    gen_cmd_t             cmd;
    logic                 cpu_ok;
    logic                 gen_hit;
    logic [NUM_CPU-1:0]   route_tgt;
    logic [NUM_CPU-1:0]   tgt_eff;
    logic [NUM_CPU-1:0]   self_1h;
    logic [PW-1:0]        gen_bits;
    logic [PW-1:0]        rd_state;
    logic [PW-1:0]        reg_set;
    logic [PW-1:0]        reg_clr;
    logic [PW-1:0]        bank_state [NUM_CPU];
    logic [SGI_NUM-1:0]   bank_any   [NUM_CPU];

    assign cmd     = decode_gen(acc_wdata);
    assign cpu_ok  = int'(acc_cpu) < NUM_CPU;
    assign gen_hit = acc_we && cpu_ok && (acc_addr == GEN_OFS);
    assign self_1h = NUM_CPU'(1) << acc_cpu;

    sgi_route #(.NUM_CPU(NUM_CPU)) u_route (
        .cmd (cmd),
        .src (acc_cpu),
        .tgt (route_tgt)
    );

    assign tgt_eff = gen_hit ? route_tgt : '0;

    always_comb begin
        gen_bits = '0;
        for (int i = 0; i < SGI_NUM; i++)
            for (int s = 0; s < NUM_CPU; s++)
                gen_bits[i*NUM_CPU + s] = (cmd.id == SGI_ID_W'(i)) && (acc_cpu == CPU_ID_W'(s));
    end

    always_comb begin
        rd_state = '0;
        for (int t = 0; t < NUM_CPU; t++)
            if (acc_cpu == CPU_ID_W'(t)) rd_state = bank_state[t];
    end

    sgi_pend_regs #(.NUM_CPU(NUM_CPU)) u_regs (
        .acc_addr  (acc_addr),
        .wr_ok     (acc_we && cpu_ok),
        .acc_wdata (acc_wdata),
        .rd_state  (rd_state),
        .wr_set    (reg_set),
        .wr_clr    (reg_clr),
        .rdata     (acc_rdata)
    );

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_bank
        logic          own;
        logic [PW-1:0] set_t;
        logic [PW-1:0] clr_t;
        assign own   = (acc_cpu == CPU_ID_W'(t));
        assign set_t = (tgt_eff[t] ? gen_bits : '0) | (own ? reg_set : '0);
        assign clr_t = own ? reg_clr : '0;

        sgi_pend_bank #(.NUM_CPU(NUM_CPU)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_vec (set_t),
            .clr_vec (clr_t),
            .state   (bank_state[t]),
            .any     (bank_any[t])
        );

        assign sgi_pend[t*SGI_NUM +: SGI_NUM] = bank_any[t];
    end

    // R5
    rsvd_route_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_hit && cmd.route == RT_RSVD) |=> $stable(sgi_pend));

    // R3
    others_skip_self_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_hit && cmd.route == RT_OTHERS) |-> ((tgt_eff & self_1h) == '0));

    // R4
    self_only_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_hit && cmd.route == RT_SELF) |-> (tgt_eff == self_1h));

    // R6
    list_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_hit && cmd.route == RT_LIST) |-> (tgt_eff == acc_wdata[16 +: NUM_CPU]));
endmodule

// File: tb/sgi_gen_bench.sv
module sgi_gen_bench;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        acc_cpu = '0;
    logic [11:0]       acc_addr = '0;
    logic              acc_we = 1'b0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic [16*NC-1:0]  sgi_pend;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_on = 0;
    bit done   = 0;

    bit ref_p [0:7][0:15][0:7];

    sgi_gen #(.NUM_CPU(NC)) u_sgi_gen (
        .clk(clk), .rst(rst), .acc_cpu(acc_cpu), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .sgi_pend(sgi_pend)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [16*NC-1:0] exp_pend();
        logic [16*NC-1:0] v = '0;
        for (int t = 0; t < NC; t++)
            for (int i = 0; i < 16; i++)
                for (int s = 0; s < NC; s++)
                    if (ref_p[t][i][s]) v[t*16+i] = 1'b1;
        return v;
    endfunction

    function automatic int bank_word(input logic [11:0] a, output int kind);
        kind = 0;
        if (a[1:0] != 0) return 0;
        if (a >= 12'hF10 && a < 12'hF20) begin kind = 1; return int'(a - 12'hF10) / 4; end
        if (a >= 12'hF20 && a < 12'hF30) begin kind = 2; return int'(a - 12'hF20) / 4; end
        return 0;
    endfunction

    function automatic logic [31:0] exp_rd(input int cpu, input logic [11:0] a);
        logic [31:0] r = '0;
        int kind;
        int w = bank_word(a, kind);
        if (cpu < NC && kind != 0)
            for (int b = 0; b < 4; b++)
                for (int s = 0; s < NC; s++)
                    r[b*8+s] = ref_p[cpu][4*w+b][s];
        return r;
    endfunction

    task automatic model_write(input int cpu, input logic [11:0] a, input logic [31:0] d);
        int kind;
        int w;
        if (cpu >= NC) return;
        if (a == 12'hF00) begin
            for (int t = 0; t < NC; t++) begin
                bit hit;
                case (d[25:24])
                    2'd0: hit = d[16+t];
                    2'd1: hit = (t != cpu);
                    2'd2: hit = (t == cpu);
                    default: hit = 0;
                endcase
                if (hit) ref_p[t][d[3:0]][cpu] = 1;
            end
        end
        w = bank_word(a, kind);
        if (kind != 0)
            for (int b = 0; b < 4; b++)
                for (int s = 0; s < NC; s++)
                    if (d[b*8+s]) ref_p[cpu][4*w+b][s] = (kind == 2);
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_cpu = 3'(cpu); acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(posedge clk);
        model_write(cpu, a, d);
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_cpu = 3'(cpu); acc_addr = a; acc_we = 1'b0;
        #1;
        check(acc_rdata === exp, tag, 64'(acc_rdata), 64'(exp));
    endtask

    task automatic rd_model(input int cpu, input logic [11:0] a, input string tag);
        rd(cpu, a, exp_rd(cpu, a), tag);
    endtask

    // R11: per-clock compare of the pending outputs against the model
    always @(negedge clk) begin
        if (cmp_on) check(sgi_pend === exp_pend(), "R11 sgi_pend", 64'(sgi_pend), 64'(exp_pend()));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 16; i++)
                for (int s = 0; s < 8; s++) ref_p[t][i][s] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        cmp_on = 1;
        // R1 reset state
        check(sgi_pend === '0, "R1 pend after reset", 64'(sgi_pend), 64'd0);
        rd(2, 12'hF2C, 32'h0, "R1 set bank after reset");
        rd(0, 12'hF10, 32'h0, "R1 clr bank after reset");

        // R2 route 0: cpu1 raises ID 5 on CPUs 0 and 2
        wr(1, 12'hF00, 32'h0005_0005);
        rd(0, 12'hF24, 32'h0000_0200, "R2 list target cpu0");
        rd(2, 12'hF14, 32'h0000_0200, "R2 list target cpu2");
        rd(1, 12'hF24, 32'h0000_0000, "R2 unlisted cpu1");

        // R3 route 1: cpu2 raises ID 9, mask ignored
        wr(2, 12'hF00, 32'h01FF_0009);
        rd(0, 12'hF28, 32'h0000_0400, "R3 others cpu0");
        rd(2, 12'hF28, 32'h0000_0000, "R3 writer excluded");
        rd_model(3, 12'hF28, "R3 others cpu3");

        // R4 route 2: cpu3 raises ID 15, mask names cpu0 only
        wr(3, 12'hF00, 32'h0201_000F);
        rd(3, 12'hF2C, 32'h0800_0000, "R4 self cpu3");
        rd(0, 12'hF2C, 32'h0000_0000, "R4 mask ignored");

        // R5 reserved route
        wr(0, 12'hF00, 32'h030F_0003);
        rd_model(0, 12'hF20, "R5 reserved no effect");
        rd_model(3, 12'hF20, "R5 reserved no effect cpu3");

        // R6 out of range targets
        wr(1, 12'hF00, 32'h00F0_0002);
        rd_model(1, 12'hF20, "R6 high mask only");
        wr(1, 12'hF00, 32'h00F8_0002);
        rd(3, 12'hF20, 32'h0002_0000, "R6 cpu3 kept");

        // R7 second source on same pair, and repeat
        wr(0, 12'hF00, 32'h0001_0005);
        wr(0, 12'hF00, 32'h0001_0005);
        rd(0, 12'hF24, 32'h0000_0300, "R7 two sources");

        // R8 set bank from cpu1, upper source bits ignored
        wr(1, 12'hF20, 32'h0000_F401);
        rd(1, 12'hF20, 32'h0000_0401, "R8 set bits");
        rd(1, 12'hF10, 32'h0000_0401, "R10 clr bank readback");
        wr(1, 12'hF2C, 32'h0000_0000);
        rd_model(1, 12'hF2C, "R8 zero write");

        // R9 clear one source, target stays pending from the other
        wr(0, 12'hF14, 32'h0000_0200);
        rd(0, 12'hF24, 32'h0000_0100, "R9 partial clear");
        check(sgi_pend[5] === 1'b1, "R11 still pending", 64'(sgi_pend[5]), 64'd1);
        wr(0, 12'hF14, 32'h0000_0100);
        check(sgi_pend[5] === 1'b0, "R11 drops", 64'(sgi_pend[5]), 64'd0);
        rd(0, 12'hF24, 32'h0, "R9 full clear");

        // R10 unimplemented source bits and generate offset read 0
        rd(1, 12'hF00, 32'h0, "R10 generate reads zero");

        // R12 stray writes and out of range requester
        wr(2, 12'hF30, 32'hFFFF_FFFF);
        wr(2, 12'hF22, 32'hFFFF_FFFF);
        wr(2, 12'hF04, 32'h0004_0001);
        wr(5, 12'hF00, 32'h000F_0001);
        wr(6, 12'hF20, 32'hFFFF_FFFF);
        rd_model(2, 12'hF20, "R12 stray writes");
        rd_model(2, 12'hF24, "R12 stray writes word1");
        rd(5, 12'hF20, 32'h0, "R12 bad cpu read");
        check(sgi_pend === exp_pend(), "R12 pend unchanged", 64'(sgi_pend), 64'(exp_pend()));

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule